// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Entry

This block is a 32-bit countdown timer for a per-core interrupt unit. Software loads a start value, picks a power-of-two prescale of an incoming bus-clock enable, and sets up a timer interrupt entry. The entry holds an 8-bit vector, a mask bit and a mode bit that selects one-shot or periodic operation. Each time the countdown reaches zero it adds one to a small pending-expiry counter. An interrupt request is raised while pending expiries remain, and each accepted request removes one.

Register writes use a select code, a 32-bit data word and a one-cycle write strobe. The current count, the stored entry and the pending count are available as outputs. A level input gives the unit-wide software enable. While it is low, the entry stays masked and all pending expiries are discarded.

Top module: `lvt_timer`

## Requirements
- R1: The prescale divisor is 1 << ((c + 1) mod 8), where the 3-bit code c = {cfg[3], cfg[1], cfg[0]} is taken from divide-config writes (select 1); cfg[2] is ignored. Codes 0 to 6 give divisors 2 to 128, and code 7 gives divide by 1.
- R2: A write to the start value (select 0) loads the count with the written value and clears the pending count. A written value of 0 leaves the timer stopped.
- R3: The current-count output reads 0 whenever the stored start value is 0.
- R4: One-shot mode (entry bit 17 = 0): the count holds at 0 after expiry. Periodic mode (bit 17 = 1): the count reloads the start value on the divided tick that expires it.
- R5: An entry write (select 2) keeps only bits [7:0] (vector), bit 12, bit 16 (mask) and bit 17 (periodic). All other bits read back as 0.
- R6: While the software enable is low, entry bit 16 is forced to 1, including on any write made in that time, and the pending count is held at 0.
- R7: The request output is high only when the software enable is high, the entry mask is 0 and the pending count is non-zero. It presents the entry vector. An acknowledge while the request is high lowers the pending count by one.
- R8: After reset the entry reads 0x0001_0000, the start value and the divide config are 0 (divide by 2), and the pending count and the request are 0.
- R9: Each expiry adds one to the pending count. The count saturates at its maximum value and does not wrap.
- R10: The prescaler restarts on every start-value or divide-config write. With a steady bus enable, the first decrement comes exactly one divisor's worth of enables after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busTick | input | 1 | Bus clock enable feeding the prescaler |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 start value, 1 divide config, 2 entry, 3 none |
| wrData | input | 32 | Write data |
| swEnable | input | 1 | Unit-wide software enable |
| irqAck | input | 1 | Timer interrupt accepted |
| curCount | output | 32 | Current countdown value |
| entryOut | output | 32 | Stored timer interrupt entry |
| pendCount | output | 3 | Pending expiry count |
| irqReq | output | 1 | Timer interrupt request |
| irqVector | output | 8 | Vector presented with the request |

## Verification
The hardest state to reach from the ports is a saturated pending counter: expiries must arrive faster than anything drains them. The stimulus selects divide by 1 and a start value of 1 in periodic mode, so the timer expires on every cycle, and leaves the request unacknowledged until the counter pins at its maximum. A second hard case is a software disable arriving while expiries are still pending and the timer is still running. The bench lets a periodic countdown build up a pending expiry, drops the enable, and confirms that the mask is set, the request falls at once, and the pending count stays at zero through several later expiries.

// File: rtl/lvt_timer_pkg.sv
`timescale 1ns/1ps
package lvt_timer_pkg;
  localparam int DIV_EXP_W = 3;
  localparam int MASK_BIT = 16;
  localparam int PERIODIC_BIT = 17;
  localparam logic [31:0] ENTRY_KEEP  = 32'h0003_10FF;
  localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadStart;
    logic preRestart;
  } dpStrobes_t;

  function automatic logic [DIV_EXP_W-1:0] packDivCode(input logic [3:0] cfg);
    return {cfg[3], cfg[1], cfg[0]};
  endfunction
endpackage

// File: rtl/lvt_timer_ctrl.sv
`timescale 1ns/1ps
module lvt_timer_ctrl
  import lvt_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int PEND_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [31:0]          wrData,
  input  logic                 swEnable,
  input  logic                 irqAck,
  input  logic                 expire,
  output dpStrobes_t           strobes,
  output logic [COUNT_W-1:0]   startVal,
  output logic [DIV_EXP_W-1:0] divCode,
  output logic                 periodic,
  output logic [31:0]          entryReg,
  output logic [PEND_W-1:0]    pendCnt,
  output logic                 irqReq
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [3:0] divCfg;
  logic       wrStart, wrDiv, wrEntry;
  logic       clearPend, decPend;

  assign wrStart = wrEn && (regSel_e'(wrSel) == SEL_START);
  assign wrDiv   = wrEn && (regSel_e'(wrSel) == SEL_DIV);
  assign wrEntry = wrEn && (regSel_e'(wrSel) == SEL_ENTRY);

  assign strobes.loadStart  = wrStart;
  assign strobes.preRestart = wrStart || wrDiv;

  assign divCode  = packDivCode(divCfg);
  assign periodic = entryReg[PERIODIC_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startVal <= '0;
      divCfg   <= '0;
    end else begin
      if (wrStart) startVal <= wrData[COUNT_W-1:0];
      if (wrDiv)   divCfg   <= wrData[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryReg <= ENTRY_RESET;
    end else if (!swEnable) begin
      entryReg <= (wrEntry ? (wrData & ENTRY_KEEP) : entryReg) | (32'd1 << MASK_BIT);
    end else if (wrEntry) begin
      entryReg <= wrData & ENTRY_KEEP;
    end
  end

  assign irqReq    = swEnable && !entryReg[MASK_BIT] && (pendCnt != '0);
  assign decPend   = irqReq && irqAck;
  assign clearPend = !swEnable || wrStart;

  always_ff @(posedge clk) begin
    if (!rstN || clearPend) begin
      pendCnt <= '0;
    end else begin
      unique case ({expire, decPend})
        2'b10:   pendCnt <= (pendCnt == PEND_MAX) ? PEND_MAX : pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == PEND_MAX && expire && !decPend && !clearPend) |=> (pendCnt == PEND_MAX));

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |=> (pendCnt == '0 && entryReg[MASK_BIT]));

  assert_ack_decrements_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck && !expire && !clearPend) |=> (pendCnt == $past(pendCnt) - 1'b1));
endmodule

// File: rtl/lvt_timer_datapath.sv
`timescale 1ns/1ps
module lvt_timer_datapath
  import lvt_timer_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busTick,
  input  dpStrobes_t           strobes,
  input  logic [COUNT_W-1:0]   loadVal,
  input  logic [COUNT_W-1:0]   startVal,
  input  logic [DIV_EXP_W-1:0] divCode,
  input  logic                 periodic,
  output logic                 expire,
  output logic [COUNT_W-1:0]   curCount
);
  localparam int PRE_W = (1 << DIV_EXP_W) - 1;

  logic [PRE_W-1:0]     preCnt;
  logic [DIV_EXP_W-1:0] expVal;
  logic [PRE_W:0]       divFull;
  logic [PRE_W-1:0]     divLimit;
  logic                 divTick;
  logic [COUNT_W-1:0]   countReg;
  logic                 running;

  assign expVal   = divCode + DIV_EXP_W'(1);
  assign divFull  = ((PRE_W+1)'(1) << expVal) - (PRE_W+1)'(1);
  assign divLimit = divFull[PRE_W-1:0];
  assign divTick  = busTick && (preCnt == divLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.preRestart) begin
      preCnt <= '0;
    end else if (busTick) begin
      preCnt <= divTick ? '0 : preCnt + 1'b1;
    end
  end

  assign expire = divTick && running && !strobes.loadStart && (countReg == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      running  <= 1'b0;
    end else if (strobes.loadStart) begin
      countReg <= loadVal;
      running  <= (loadVal != '0);
    end else if (expire) begin
      if (periodic) begin
        countReg <= startVal;
      end else begin
        countReg <= '0;
        running  <= 1'b0;
      end
    end else if (divTick && running) begin
      countReg <= countReg - 1'b1;
    end
  end

  assign curCount = (startVal == '0) ? '0 : countReg;

  assert_zero_load_stops_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStart && loadVal == '0) |=> (countReg == '0 && !running));

  assert_oneshot_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !periodic) |=> (countReg == '0 && !running));

  assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (expire && periodic) |=> (countReg == $past(startVal)));

  assert_zero_start_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadStart && loadVal == '0) |=> (curCount == '0));
endmodule

// File: rtl/lvt_timer.sv
`timescale 1ns/1ps
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int PEND_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busTick,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  input  logic               swEnable,
  input  logic               irqAck,
  output logic [COUNT_W-1:0] curCount,
  output logic [31:0]        entryOut,
  output logic [PEND_W-1:0]  pendCount,
  output logic               irqReq,
  output logic [7:0]         irqVector
);
  dpStrobes_t           strobes;
  logic [COUNT_W-1:0]   startVal;
  logic [DIV_EXP_W-1:0] divCode;
  logic                 periodic;
  logic                 expire;

  lvt_timer_ctrl #(.COUNT_W(COUNT_W), .PEND_W(PEND_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .swEnable(swEnable), .irqAck(irqAck), .expire(expire), .strobes(strobes),
    .startVal(startVal), .divCode(divCode), .periodic(periodic),
    .entryReg(entryOut), .pendCnt(pendCount), .irqReq(irqReq)
  );

  lvt_timer_datapath #(.COUNT_W(COUNT_W)) uDp (
    .clk(clk), .rstN(rstN), .busTick(busTick), .strobes(strobes),
    .loadVal(wrData[COUNT_W-1:0]), .startVal(startVal), .divCode(divCode),
    .periodic(periodic), .expire(expire), .curCount(curCount)
  );

  assign irqVector = entryOut[7:0];
endmodule

// File: tb/sim_lvt_timer.sv
`timescale 1ns/1ps
module sim_lvt_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busTick = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd3;
  logic [31:0] wrData = '0;
  logic swEnable = 1'b0;
  logic irqAck = 1'b0;
  logic [31:0] curCount;
  logic [31:0] entryOut;
  logic [2:0] pendCount;
  logic irqReq;
  logic [7:0] irqVector;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    int sig;
    logic [31:0] exp;
    string req;
  } item_t;
  item_t sbQ[$];

  localparam int S_COUNT = 0, S_ENTRY = 1, S_PEND = 2, S_IRQ = 3, S_VEC = 4;

  always #2.5 clk = ~clk;

  lvt_timer u0 (
    .clk(clk), .rstN(rstN), .busTick(busTick), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .swEnable(swEnable), .irqAck(irqAck), .curCount(curCount),
    .entryOut(entryOut), .pendCount(pendCount), .irqReq(irqReq), .irqVector(irqVector)
  );

  function automatic logic [31:0] observe(input int sig);
    case (sig)
      S_COUNT: return curCount;
      S_ENTRY: return entryOut;
      S_PEND:  return {29'd0, pendCount};
      S_IRQ:   return {31'd0, irqReq};
      default: return {24'd0, irqVector};
    endcase
  endfunction

  task automatic expectVal(input int sig, input logic [31:0] v, input string r);
    item_t it;
    it.sig = sig; it.exp = v; it.req = r;
    sbQ.push_back(it);
  endtask

  initial begin
    forever begin
      wait (sbQ.size() != 0);
      #1;
      while (sbQ.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        act = observe(it.sig);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s signal=%0d actual=0x%08h expected=0x%08h", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R8 and R3: reset state
    expectVal(S_ENTRY, 32'h0001_0000, "R8");
    expectVal(S_PEND, 0, "R8");
    expectVal(S_IRQ, 0, "R8");
    expectVal(S_COUNT, 0, "R3");
    @(negedge clk);
    swEnable = 1'b1;

    // R10/R1: divide by 2 after reset, one-shot start value 3
    writeReg(2'd0, 32'd3);
    expectVal(S_COUNT, 3, "R2");
    idle(5);
    expectVal(S_COUNT, 1, "R10");
    expectVal(S_PEND, 0, "R10");
    idle(1);
    expectVal(S_COUNT, 0, "R1");
    expectVal(S_PEND, 1, "R9");
    idle(10);
    expectVal(S_COUNT, 0, "R4");
    expectVal(S_PEND, 1, "R4");
    expectVal(S_IRQ, 0, "R7");

    // R5/R7: entry field filtering, unmasked request, acknowledge
    writeReg(2'd2, 32'hFFFE_FFFF);
    expectVal(S_ENTRY, 32'h0002_10FF, "R5");
    expectVal(S_IRQ, 1, "R7");
    expectVal(S_VEC, 32'hFF, "R7");
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    expectVal(S_PEND, 0, "R7");
    expectVal(S_IRQ, 0, "R7");

    // R4/R1: periodic mode with divide by 4
    writeReg(2'd2, 32'h0002_0040);
    writeReg(2'd1, 32'h1);
    writeReg(2'd0, 32'd2);
    idle(3);
    expectVal(S_COUNT, 2, "R1");
    idle(1);
    expectVal(S_COUNT, 1, "R1");
    idle(4);
    expectVal(S_COUNT, 2, "R4");
    expectVal(S_PEND, 1, "R4");
    idle(8);
    expectVal(S_PEND, 2, "R9");
    expectVal(S_IRQ, 1, "R7");
    expectVal(S_VEC, 32'h40, "R7");

    // R2/R3: zero start value stops and clears
    writeReg(2'd0, 32'd0);
    expectVal(S_COUNT, 0, "R2");
    expectVal(S_PEND, 0, "R2");
    idle(20);
    expectVal(S_COUNT, 0, "R3");
    expectVal(S_PEND, 0, "R2");

    // R1: code 7 gives divide by 1
    writeReg(2'd1, 32'hB);
    writeReg(2'd0, 32'd5);
    expectVal(S_COUNT, 5, "R2");
    idle(4);
    expectVal(S_COUNT, 1, "R1");
    idle(1);
    expectVal(S_COUNT, 5, "R1");
    expectVal(S_PEND, 1, "R1");

    // R1: cfg bit 2 ignored, divide by 2
    writeReg(2'd1, 32'h4);
    writeReg(2'd0, 32'd4);
    expectVal(S_PEND, 0, "R2");
    idle(1);
    expectVal(S_COUNT, 4, "R1");
    idle(1);
    expectVal(S_COUNT, 3, "R1");

    // R9: saturation with an expiry every cycle
    writeReg(2'd1, 32'hB);
    writeReg(2'd0, 32'd1);
    idle(12);
    expectVal(S_PEND, 7, "R9");
    expectVal(S_COUNT, 1, "R9");

    // R6: software disable with pending expiries and a running timer
    writeReg(2'd0, 32'd0);
    writeReg(2'd1, 32'h0);
    writeReg(2'd0, 32'd3);
    idle(6);
    expectVal(S_PEND, 1, "R6");
    expectVal(S_IRQ, 1, "R7");
    @(negedge clk);
    swEnable = 1'b0;
    expectVal(S_IRQ, 0, "R7");
    @(negedge clk);
    expectVal(S_PEND, 0, "R6");
    expectVal(S_ENTRY, 32'h0003_0040, "R6");
    writeReg(2'd2, 32'h0000_0033);
    expectVal(S_ENTRY, 32'h0001_0033, "R6");
    idle(12);
    expectVal(S_PEND, 0, "R6");
    expectVal(S_IRQ, 0, "R6");
    @(negedge clk);
    swEnable = 1'b1;
    writeReg(2'd2, 32'h0000_0033);
    expectVal(S_ENTRY, 32'h0000_0033, "R5");

    idle(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule